// File: doc/BRIEF.md
# ECC Fault Capture and Interrupt Unit

This block collects uncorrectable ECC fault events from two memory sources, a RAM and a flash. It sits behind a small byte-wide register bus. Each source has its own reporting enable. When a source is enabled and raises an uncorrectable fault, the block records it in a one-hot status register. It also latches a capture record for that source: the faulting address, data, access attributes and the number of the bus master. Software reads the record later to analyse the fault.

One level interrupt request combines the enables with the status bits. Software clears a status bit by writing a one to it. Only the most recent enabled event is kept in the status register. Because the status is one-hot, the bit that is set always points at the capture record that belongs to it.

The fault inputs are plain one-cycle valid strobes with no ready signal. The block accepts an event on every clock and never applies back-pressure. Register reads are combinational and have no side effects. A write takes effect at the clock edge on which it is presented.

Top module: `ecc_fault_capture`

## Requirements
- R1: The configuration register is at offset 0x00. Bit 1 is the RAM reporting enable and bit 0 is the flash reporting enable. Bits 7:2 always read 0 and ignore writes, so writing 0xFF reads back 0x03.
- R2: After reset the configuration, the status, both capture records and `irq` are all zero.
- R3: `irq` is high exactly when (configuration bit 1 AND status bit 1) OR (configuration bit 0 AND status bit 0). It follows configuration changes without needing a new event.
- R4: The status register at offset 0x01 never has more than one bit set. Bit 1 flags a RAM fault and bit 0 flags a flash fault.
- R5: A RAM fault strobe with the RAM enable set makes the status read 0x02 from the next cycle on, replacing any flash bit. The same edge captures the RAM record.
- R6: The RAM record is read at offsets 0x10+k and the flash record at 0x20+k. Bytes k=0..3 hold the address and k=4..7 hold the data, each least significant byte first. Byte 8 holds the attributes, and byte 9 holds the master number in bits 3:0 with bits 7:4 zero.
- R7: A fault strobe from a source whose enable is clear changes neither the status nor that source's record.
- R8: Writing to offset 0x01 clears every status bit written as one. If an enabled fault arrives on the same edge, the fault sets the status instead.
- R9: When enabled RAM and flash faults arrive on the same edge, only the RAM fault sets the status and is captured. The flash record keeps its old value.
- R10: A record changes only on an enabled fault from its own source. Reads change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_sel is high |
| ram_err_valid | input | 1 | RAM uncorrectable fault strobe |
| ram_err_addr | input | ADDR_W | RAM faulting address |
| ram_err_data | input | DATA_W | RAM faulting data |
| ram_err_attr | input | ATTR_W | RAM access attributes |
| ram_err_master | input | MID_W | RAM faulting bus master number |
| flash_err_valid | input | 1 | Flash uncorrectable fault strobe |
| flash_err_addr | input | ADDR_W | Flash faulting address |
| flash_err_data | input | DATA_W | Flash faulting data |
| flash_err_attr | input | ATTR_W | Flash access attributes |
| flash_err_master | input | MID_W | Flash faulting bus master number |
| irq | output | 1 | Level interrupt request |

## Verification
A vector table walks every combination of the two enables, the two fault strobes and the clear masks, while the status carries over from one row to the next. This separates four effects: a RAM fault overriding a flash fault, a clear losing to a fault on the same edge, a disabled source being ignored, and the interrupt dropping when only the enable is removed. Directed sequences then load known records and read them byte by byte. These sequences show that the byte layout is right, that a disabled or losing source leaves its record untouched, and that one source's event leaves the other record alone.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
  localparam int unsigned NSRC      = 2;
  localparam int unsigned SRC_FLASH = 0;
  localparam int unsigned SRC_RAM   = 1;
  localparam logic [7:0]  OFS_CFG   = 8'h00;
  localparam logic [7:0]  OFS_STAT  = 8'h01;
  // Record window base per source index (index 0 flash, index 1 RAM)
  localparam logic [7:0]  REC_BASE [NSRC] = '{8'h20, 8'h10};
endpackage

// File: rtl/ecc_cap_cfg.sv
module ecc_cap_cfg
  import ecc_cap_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [NSRC-1:0] wr_bits,
  output logic [NSRC-1:0] en_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= wr_bits;
  end
endmodule

// File: rtl/ecc_cap_status.sv
module ecc_cap_status
  import ecc_cap_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] hit,
  input  logic [NSRC-1:0] clr,
  input  logic [NSRC-1:0] en,
  output logic [NSRC-1:0] take,
  output logic [NSRC-1:0] stat_q,
  output logic            irq
);
  // RAM outranks flash when both are enabled in the same cycle
  always_comb begin
    take = '0;
    if (hit[SRC_RAM])        take[SRC_RAM]   = 1'b1;
    else if (hit[SRC_FLASH]) take[SRC_FLASH] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     stat_q <= '0;
    else if (|take) stat_q <= take;
    else            stat_q <= stat_q & ~clr;
  end

  assign irq = |(en & stat_q);
endmodule

// File: rtl/ecc_cap_store.sv
module ecc_cap_store #(
  parameter int unsigned REC_W = 76
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap,
  input  logic [REC_W-1:0] rec_in,
  output logic [REC_W-1:0] rec_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rec_q <= '0;
    else if (cap) rec_q <= rec_in;
  end
endmodule

// File: rtl/ecc_fault_capture.sv
module ecc_fault_capture
  import ecc_cap_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ATTR_W = 8,
  parameter int unsigned MID_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [7:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              ram_err_valid,
  input  logic [ADDR_W-1:0] ram_err_addr,
  input  logic [DATA_W-1:0] ram_err_data,
  input  logic [ATTR_W-1:0] ram_err_attr,
  input  logic [MID_W-1:0]  ram_err_master,
  input  logic              flash_err_valid,
  input  logic [ADDR_W-1:0] flash_err_addr,
  input  logic [DATA_W-1:0] flash_err_data,
  input  logic [ATTR_W-1:0] flash_err_attr,
  input  logic [MID_W-1:0]  flash_err_master,
  output logic              irq
);
  localparam int unsigned REC_W     = ADDR_W + DATA_W + ATTR_W + MID_W;
  localparam int unsigned REC_BYTES = (REC_W + 7) / 8;
  localparam int unsigned PAD_W     = REC_BYTES * 8;
  typedef logic [PAD_W-1:0] pad_t;

  logic [NSRC-1:0]  en_q, stat_q, take, hit, clr, valid;
  logic [REC_W-1:0] rec_in [NSRC];
  logic [REC_W-1:0] rec_q  [NSRC];
  pad_t             rec_pad [NSRC];
  logic             cfg_wr, stat_wr;
  logic [5:0]       wdata_unused;

  assign cfg_wr       = bus_sel && bus_wr && (bus_addr == OFS_CFG);
  assign stat_wr      = bus_sel && bus_wr && (bus_addr == OFS_STAT);
  assign clr          = stat_wr ? bus_wdata[NSRC-1:0] : '0;
  assign wdata_unused = bus_wdata[7:2];

  assign valid[SRC_RAM]    = ram_err_valid;
  assign valid[SRC_FLASH]  = flash_err_valid;
  assign rec_in[SRC_RAM]   = {ram_err_master, ram_err_attr, ram_err_data, ram_err_addr};
  assign rec_in[SRC_FLASH] = {flash_err_master, flash_err_attr, flash_err_data, flash_err_addr};
  assign hit = valid & en_q;

  ecc_cap_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr),
    .wr_bits(bus_wdata[NSRC-1:0]), .en_q(en_q)
  );

  ecc_cap_status u_status (
    .clk(clk), .rst_n(rst_n), .hit(hit), .clr(clr), .en(en_q),
    .take(take), .stat_q(stat_q), .irq(irq)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    ecc_cap_store #(.REC_W(REC_W)) u_store (
      .clk(clk), .rst_n(rst_n), .cap(take[s]),
      .rec_in(rec_in[s]), .rec_q(rec_q[s])
    );
    assign rec_pad[s] = pad_t'(rec_q[s]);
  end

  always_comb begin
    logic [7:0] off;
    bus_rdata = '0;
    off       = '0;
    if (bus_sel) begin
      if (bus_addr == OFS_CFG)       bus_rdata = {6'b0, en_q};
      else if (bus_addr == OFS_STAT) bus_rdata = {6'b0, stat_q};
      else begin
        for (int s = 0; s < NSRC; s++) begin
          off = bus_addr - REC_BASE[s];
          if (bus_addr >= REC_BASE[s] && off < 8'(REC_BYTES))
            bus_rdata = rec_pad[s][{off, 3'b000} +: 8];
        end
      end
    end
  end
endmodule

// File: rtl/ecc_cap_checker.sv
module ecc_cap_checker #(
  parameter int unsigned REC_W = 76
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       en,
  input logic [1:0]       stat,
  input logic             ram_v,
  input logic             fl_v,
  input logic [REC_W-1:0] ram_rec,
  input logic [REC_W-1:0] fl_rec,
  input logic             irq,
  input logic             bus_sel,
  input logic [7:0]       bus_addr,
  input logic [7:0]       bus_rdata
);
  p_cfg_reserved_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_addr == 8'h00) |-> (bus_rdata[7:2] == 6'b0));

  p_irq_after_ram_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_v && en[1]) |=> irq);

  p_stat_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stat));

  p_ram_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_v && en[1]) |=> (stat == 2'b10));

  p_ram_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_v && en[1]) |=> $stable(ram_rec));

  p_flash_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_v && en[0] && !(ram_v && en[1])) |=> $stable(fl_rec));

  p_flash_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_v && en[0] && !(ram_v && en[1])) |=> (stat == 2'b01));
endmodule

bind ecc_fault_capture ecc_cap_checker #(.REC_W(REC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en_q), .stat(stat_q),
  .ram_v(ram_err_valid), .fl_v(flash_err_valid),
  .ram_rec(rec_q[1]), .fl_rec(rec_q[0]), .irq(irq),
  .bus_sel(bus_sel), .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/test_ecc_fault_capture.sv
module test_ecc_fault_capture;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 20000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [7:0]  bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic        ram_err_valid = 0, flash_err_valid = 0;
  logic [31:0] ram_err_addr = 0, ram_err_data = 0, flash_err_addr = 0, flash_err_data = 0;
  logic [7:0]  ram_err_attr = 0, flash_err_attr = 0;
  logic [3:0]  ram_err_master = 0, flash_err_master = 0;
  logic        irq;
  int          checks = 0, errors = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_fault_capture i_ecc_fault_capture (.*);

  // {cfg[1:0], ram, flash, clr[1:0], exp_stat[1:0], exp_irq}
  localparam int NV = 13;
  localparam logic [8:0] VEC [NV] = '{
    9'b11_1_0_00_10_1, 9'b11_0_1_00_01_1, 9'b11_1_1_00_10_1,
    9'b11_0_0_10_00_0, 9'b01_1_0_00_00_0, 9'b01_1_1_00_01_1,
    9'b10_0_0_00_01_0, 9'b10_0_1_00_01_0, 9'b10_1_0_10_10_1,
    9'b10_0_0_01_10_1, 9'b00_1_0_10_00_0, 9'b11_0_1_01_01_1,
    9'b11_0_0_11_00_0};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic set_ram(input logic [31:0] a, input logic [31:0] dt, input logic [7:0] t, input logic [3:0] m);
    ram_err_addr = a; ram_err_data = dt; ram_err_attr = t; ram_err_master = m;
  endtask

  task automatic set_flash(input logic [31:0] a, input logic [31:0] dt, input logic [7:0] t, input logic [3:0] m);
    flash_err_addr = a; flash_err_data = dt; flash_err_attr = t; flash_err_master = m;
  endtask

  // one edge with fault strobes and an optional status clear
  task automatic pulse(input logic r, input logic f, input logic [1:0] clr);
    @(negedge clk);
    ram_err_valid = r; flash_err_valid = f;
    if (clr != 0) begin bus_sel = 1; bus_wr = 1; bus_addr = 8'h01; bus_wdata = {6'b0, clr}; end
    @(negedge clk);
    ram_err_valid = 0; flash_err_valid = 0; bus_sel = 0; bus_wr = 0;
  endtask

  task automatic check_rec(input string tag, input logic [7:0] base, input logic [31:0] a,
                           input logic [31:0] dt, input logic [7:0] t, input logic [3:0] m);
    logic [79:0] exp_rec;
    logic [7:0]  d;
    exp_rec = {4'b0, m, t, dt, a};
    for (int k = 0; k < 10; k++) begin
      bus_read(base + 8'(k), d);
      check($sformatf("%s byte %0d", tag, k), {24'b0, d}, {24'b0, exp_rec[k*8 +: 8]});
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, d2;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R2: reset state
    check("R2 irq", {31'b0, irq}, 0);
    bus_read(8'h00, d); check("R2 cfg", {24'b0, d}, 0);
    bus_read(8'h01, d); check("R2 status", {24'b0, d}, 0);
    bus_read(8'h10, d); check("R2 ram record", {24'b0, d}, 0);
    bus_read(8'h29, d); check("R2 flash record", {24'b0, d}, 0);

    // R1: reserved bits ignore writes
    bus_write(8'h00, 8'hFF);
    bus_read(8'h00, d); check("R1 cfg readback", {24'b0, d}, 32'h03);

    // table walk: R3 R4 R5 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      logic [8:0] v;
      v = VEC[i];
      set_ram(32'h1000 + i, 32'h2000 + i, 8'(i), 4'(i));
      set_flash(32'h3000 + i, 32'h4000 + i, 8'(i), 4'(i));
      bus_write(8'h00, {6'b0, v[8:7]});
      pulse(v[6], v[5], v[4:3]);
      check($sformatf("R3 irq row %0d", i), {31'b0, irq}, {31'b0, v[0]});
      bus_read(8'h01, d);
      check($sformatf("R4 R5 R8 R9 status row %0d", i), {24'b0, d}, {30'b0, v[2:1]});
    end

    // R6: RAM record layout
    bus_write(8'h00, 8'h03);
    set_ram(32'h12345678, 32'hCAFEF00D, 8'hA5, 4'h9);
    pulse(1, 0, 2'b00);
    check_rec("R6 ram", 8'h10, 32'h12345678, 32'hCAFEF00D, 8'hA5, 4'h9);

    // R10: reads have no side effects
    bus_read(8'h01, d); bus_read(8'h01, d2);
    check("R10 status stable across reads", {24'b0, d2}, {24'b0, d});
    check("R10 status value", {24'b0, d2}, 32'h02);

    // R6: flash record layout
    set_flash(32'h89ABCDEF, 32'h01020304, 8'h3C, 4'h6);
    pulse(0, 1, 2'b00);
    check_rec("R6 flash", 8'h20, 32'h89ABCDEF, 32'h01020304, 8'h3C, 4'h6);
    check_rec("R10 ram kept", 8'h10, 32'h12345678, 32'hCAFEF00D, 8'hA5, 4'h9);

    // R7: disabled flash leaves status and record alone
    bus_write(8'h00, 8'h02);
    set_flash(32'h55555555, 32'h66666666, 8'h77, 4'h8);
    pulse(0, 1, 2'b00);
    bus_read(8'h01, d); check("R7 status unchanged", {24'b0, d}, 32'h01);
    check_rec("R7 flash kept", 8'h20, 32'h89ABCDEF, 32'h01020304, 8'hA5 ^ 8'h99, 4'h6);

    // R9: simultaneous faults, RAM captured, flash record untouched
    bus_write(8'h00, 8'h03);
    set_ram(32'hDEADBEEF, 32'h0BADC0DE, 8'h11, 4'h2);
    set_flash(32'hAAAA0000, 32'hBBBB0000, 8'h22, 4'h3);
    pulse(1, 1, 2'b00);
    bus_read(8'h01, d); check("R9 status", {24'b0, d}, 32'h02);
    check_rec("R9 ram", 8'h10, 32'hDEADBEEF, 32'h0BADC0DE, 8'h11, 4'h2);
    check_rec("R9 flash kept", 8'h20, 32'h89ABCDEF, 32'h01020304, 8'h3C, 4'h6);

    // R3: dropping the enable alone drops irq
    check("R3 irq set", {31'b0, irq}, 1);
    bus_write(8'h00, 8'h01);
    check("R3 irq after enable cleared", {31'b0, irq}, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule